// File: doc/BRIEF.md
# Key-Value System Controller Port

This block is a byte-wide I/O-port slave that answers a small key-addressed read protocol. It decodes an aligned window of I/O addresses and uses two ports inside it: a data port and a command/status port. To fetch a value, the host first writes the read command to the command port. It then writes four key-name bytes and one length byte to the data port. Finally it reads the value bytes back from the data port, polling the status byte on the command port between reads.

Values come from a fixed key table built at elaboration. The table holds a revision key and three one-byte flags. It also holds two keys that each carry one half of a 64-byte secret, which is supplied as a parameter. When the value fed to that parameter is not marked as exactly 64 characters long, a computed placeholder secret is used in its place. A lookup that matches copies the entry's bytes into a 255-byte output buffer. A lookup that misses leaves the buffer untouched, so its old contents are streamed out.

Top module: `kv_ctrl_port`

## Requirements
- R1: With default parameters the window is 0x300..0x31F. Only 0x300 (data) and 0x304 (command/status) respond. A read at any other address returns 0x00, and an access at any other address changes no state.
- R2: A write to the command port latches the byte as the current command and clears the key-input and data-output positions. Writing 0x10 sets status to 0x0C. Any other code, for example 0x11, leaves status as it was, and under such a command data writes are ignored.
- R3: Under command 0x10, data writes one to four are stored in order as key name bytes. The first byte written is the first character of the name. Status reads 0x04 after each of these writes.
- R4: Under command 0x10, the fifth data write sets the requested length. It also sets status to 0x05 and the output position to 0. On a key match, the first N buffer bytes are overwritten with the entry's N value bytes. Buffer bytes beyond N keep their old values.
- R5: Under command 0x10, each data read with the position below the length returns the buffer byte at that position and advances the position. Status stays 0x05 until the read that reaches the length, which sets it to 0x00.
- R6: A data read past the requested length, or under any command other than 0x10, returns 0x00 and changes no state.
- R7: When the key matches no entry, the output buffer is unchanged and its earlier contents are streamed out.
- R8: The key "REV " holds 6 bytes: 01 13 0F 00 00 03. The keys "NATJ" and "MSSP" each hold one byte 00. The key "MSSD" holds one byte 03.
- R9: The key "OSK0" returns secret bytes 0..31 and "OSK1" returns secret bytes 32..63. Secret byte i is SECRET[8i+7:8i]. When SECRET_LEN is not 64, secret byte i is 0xA5 XOR i instead.
- R10: A read of the command port returns the status byte and changes no state.
- R11: Data writes after the fifth one of a read transaction are ignored. The write position saturates and does not wrap.
- R12: After reset the command, status, positions, key, length and buffer are all 0. A command port read returns 0x00 and a data port read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one byte per cycle; takes priority over io_rd |
| io_rd | input | 1 | Read strobe, one byte per cycle |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data, valid in the cycle of io_rd; 0 when not reading |

## Verification
The bench runs a behavioural model with its own key table and buffer alongside two instances. One instance is given a valid secret and the other a secret of the wrong length. Every cycle it compares the read data of both against the model. It targets the following cases:
- A zero-length request, where a design that streams anyway would return buffer bytes instead of zero.
- A requested length longer than the matching entry, where a design that clears the tail would lose the stale bytes.
- A missing key, where a design that zeroes or reloads the buffer would break the stale-stream rule.
- Extra data writes after the length, where a wrapping position would overwrite the key.
- A command rewrite in the middle of a read, and accesses to unused offsets inside and outside the window, which expose a position that is not cleared and a loose address decode.

// File: rtl/kv_pkg.sv
package kv_pkg;

    localparam int KEY_BYTES    = 4;
    localparam int SECRET_BYTES = 64;
    localparam int VAL_MAX      = SECRET_BYTES / 2;
    localparam int LEN_W        = $clog2(VAL_MAX + 1);

    localparam logic [7:0] CMD_READ = 8'h10;

    localparam logic [7:0] ST_IDLE = 8'h00;
    localparam logic [7:0] ST_CMD  = 8'h0C;
    localparam logic [7:0] ST_KEY  = 8'h04;
    localparam logic [7:0] ST_DATA = 8'h05;

    localparam logic [2:0] WPOS_LEN  = 3'd4;
    localparam logic [2:0] WPOS_DONE = 3'd5;

    typedef struct packed {
        logic [7:0]              cmd;
        logic [7:0]              status;
        logic [2:0]              wpos;
        logic [7:0]              rpos;
        logic [8*KEY_BYTES-1:0]  key;
        logic [7:0]              len;
    } port_state_t;

    function automatic logic [8*SECRET_BYTES-1:0] placeholder_secret();
        logic [8*SECRET_BYTES-1:0] s;
        s = '0;
        for (int i = 0; i < SECRET_BYTES; i++) begin
            s[8*i +: 8] = 8'hA5 ^ 8'(i);
        end
        return s;
    endfunction

endpackage

// File: rtl/kv_addr_dec.sv
module kv_addr_dec #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h0300,
    parameter int              WINDOW   = 32,
    parameter int              DATA_OFF = 0,
    parameter int              CMD_OFF  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              data_sel,
    output logic              cmd_sel
);
    localparam int OFF_W = $clog2(WINDOW);

    logic              in_win;
    logic [OFF_W-1:0]  off;

    always_comb begin
        in_win   = (addr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]);
        off      = addr[OFF_W-1:0];
        data_sel = in_win && (off == OFF_W'(DATA_OFF));
        cmd_sel  = in_win && (off == OFF_W'(CMD_OFF));
    end
endmodule

// File: rtl/kv_key_table.sv
module kv_key_table
    import kv_pkg::*;
#(
    parameter logic [8*SECRET_BYTES-1:0] SECRET     = '0,
    parameter int                        SECRET_LEN = 0
) (
    input  logic [8*KEY_BYTES-1:0]   key,
    output logic                     hit,
    output logic [LEN_W-1:0]         len,
    output logic [VAL_MAX-1:0][7:0]  val
);
    localparam logic [8*SECRET_BYTES-1:0] SEC_EFF =
        (SECRET_LEN == SECRET_BYTES) ? SECRET : placeholder_secret();

    always_comb begin
        hit = 1'b0;
        len = '0;
        val = '0;
        case (key)
            "REV ": begin
                hit    = 1'b1;
                len    = LEN_W'(6);
                val[0] = 8'h01;
                val[1] = 8'h13;
                val[2] = 8'h0F;
                val[3] = 8'h00;
                val[4] = 8'h00;
                val[5] = 8'h03;
            end
            "OSK0": begin
                hit = 1'b1;
                len = LEN_W'(VAL_MAX);
                for (int i = 0; i < VAL_MAX; i++) val[i] = SEC_EFF[8*i +: 8];
            end
            "OSK1": begin
                hit = 1'b1;
                len = LEN_W'(VAL_MAX);
                for (int i = 0; i < VAL_MAX; i++) val[i] = SEC_EFF[8*(i+VAL_MAX) +: 8];
            end
            "NATJ", "MSSP": begin
                hit    = 1'b1;
                len    = LEN_W'(1);
                val[0] = 8'h00;
            end
            "MSSD": begin
                hit    = 1'b1;
                len    = LEN_W'(1);
                val[0] = 8'h03;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/kv_out_buf.sv
module kv_out_buf
    import kv_pkg::*;
#(
    parameter int DEPTH  = 255,
    parameter int LOAD_W = VAL_MAX
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [LEN_W-1:0]        load_len,
    input  logic [LOAD_W-1:0][7:0]  load_val,
    input  logic [7:0]              rd_idx,
    output logic [7:0]              rd_byte
);
    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        if (g < LOAD_W) begin : g_load
            always_comb begin
                mem_d[g] = mem_q[g];
                if (load_en && (32'(load_len) > g)) mem_d[g] = load_val[g];
            end
        end else begin : g_hold
            always_comb mem_d[g] = mem_q[g];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    always_comb begin
        rd_byte = '0;
        if (32'(rd_idx) < DEPTH) rd_byte = mem_q[rd_idx];
    end

    AST_LOAD_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (32'(load_len) <= LOAD_W)); // R8
endmodule

// File: rtl/kv_ctrl_port.sv
module kv_ctrl_port
    import kv_pkg::*;
#(
    parameter int                        ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]         BASE_ADDR  = 16'h0300,
    parameter int                        WINDOW     = 32,
    parameter int                        DATA_OFF   = 0,
    parameter int                        CMD_OFF    = 4,
    parameter int                        BUF_DEPTH  = 255,
    parameter logic [8*SECRET_BYTES-1:0] SECRET     = '0,
    parameter int                        SECRET_LEN = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata
);
    port_state_t st_q, st_d;

    logic                    data_sel, cmd_sel;
    logic                    tbl_hit;
    logic [LEN_W-1:0]        tbl_len;
    logic [VAL_MAX-1:0][7:0] tbl_val;
    logic                    load_en;
    logic [7:0]              buf_byte;
    logic                    rd_ok;
    logic [7:0]              rpos_nx;

    kv_addr_dec #(
        .ADDR_W(ADDR_W), .BASE(BASE_ADDR), .WINDOW(WINDOW),
        .DATA_OFF(DATA_OFF), .CMD_OFF(CMD_OFF)
    ) u_dec (
        .addr(io_addr), .data_sel(data_sel), .cmd_sel(cmd_sel)
    );

    kv_key_table #(.SECRET(SECRET), .SECRET_LEN(SECRET_LEN)) u_tbl (
        .key(st_q.key), .hit(tbl_hit), .len(tbl_len), .val(tbl_val)
    );

    kv_out_buf #(.DEPTH(BUF_DEPTH), .LOAD_W(VAL_MAX)) u_buf (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_len(tbl_len),
        .load_val(tbl_val), .rd_idx(st_q.rpos), .rd_byte(buf_byte)
    );

    always_comb begin
        st_d     = st_q;
        io_rdata = '0;
        load_en  = 1'b0;
        rpos_nx  = st_q.rpos + 8'd1;
        rd_ok    = data_sel && io_rd && !io_wr && (st_q.cmd == CMD_READ)
                   && (st_q.rpos < st_q.len);
        if (io_wr && cmd_sel) begin
            st_d.cmd  = io_wdata;
            st_d.wpos = '0;
            st_d.rpos = '0;
            if (io_wdata == CMD_READ) st_d.status = ST_CMD;
        end else if (io_wr && data_sel && (st_q.cmd == CMD_READ)) begin
            if (st_q.wpos < WPOS_LEN) begin
                st_d.key[8*(3 - 32'(st_q.wpos[1:0])) +: 8] = io_wdata;
                st_d.status = ST_KEY;
                st_d.wpos   = st_q.wpos + 3'd1;
            end else if (st_q.wpos == WPOS_LEN) begin
                st_d.len    = io_wdata;
                st_d.status = ST_DATA;
                st_d.rpos   = '0;
                st_d.wpos   = WPOS_DONE;
                load_en     = tbl_hit;
            end
        end else if (rd_ok) begin
            io_rdata    = buf_byte;
            st_d.rpos   = rpos_nx;
            st_d.status = (rpos_nx == st_q.len) ? ST_IDLE : ST_DATA;
        end else if (io_rd && !io_wr && cmd_sel) begin
            io_rdata = st_q.status;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CMD_CLEARS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && cmd_sel) |=> (st_q.wpos == 3'd0 && st_q.rpos == 8'd0)); // R2
    AST_READ_CMD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && cmd_sel && io_wdata == CMD_READ) |=> (st_q.status == ST_CMD)); // R2
    AST_KEY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && data_sel && st_q.cmd == CMD_READ && st_q.wpos < WPOS_LEN)
        |=> (st_q.status == ST_KEY)); // R3
    AST_LEN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && data_sel && st_q.cmd == CMD_READ && st_q.wpos == WPOS_LEN)
        |=> (st_q.status == ST_DATA && st_q.rpos == 8'd0)); // R4
    AST_WPOS_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && data_sel && st_q.wpos == WPOS_DONE)
        |=> (st_q.wpos == WPOS_DONE && $stable(st_q.key) && $stable(st_q.len))); // R11
    AST_STATUS_PEEK: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && cmd_sel) |=> ($stable(st_q.status) && $stable(st_q.rpos))); // R10
    AST_RPOS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rpos <= st_q.len) || (st_q.len == 8'd0 && st_q.rpos == 8'd0)); // R5
    AST_PAST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && data_sel && st_q.rpos == st_q.len)
        |-> (io_rdata == 8'h00)); // R6
endmodule

// File: tb/sim_kv_ctrl_port.sv
module sim_kv_ctrl_port;
    localparam int CLK_PERIOD = 10;

    function automatic logic [511:0] make_secret();
        logic [511:0] s;
        for (int i = 0; i < 64; i++) s[8*i +: 8] = 8'((i * 7 + 3) & 255);
        return s;
    endfunction
    localparam logic [511:0] CFG_SECRET = make_secret();

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  rdata0, rdata1;

    int checks = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kv_ctrl_port #(.SECRET(CFG_SECRET), .SECRET_LEN(64)) u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(rdata0));
    kv_ctrl_port #(.SECRET(CFG_SECRET), .SECRET_LEN(63)) u1 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(rdata1));

    // behavioural reference model, one copy per instance
    logic [7:0]  m_cmd [2], m_st [2], m_len [2];
    int          m_wpos [2], m_rpos [2];
    logic [31:0] m_key [2];
    byte unsigned m_buf [2][255];

    function automatic byte unsigned sec_byte(int k, int i);
        if (k == 0) return byte'((i * 7 + 3) & 255);
        return byte'(8'hA5 ^ 8'(i));
    endfunction

    function automatic void model_reset();
        for (int k = 0; k < 2; k++) begin
            m_cmd[k] = 0; m_st[k] = 0; m_len[k] = 0;
            m_wpos[k] = 0; m_rpos[k] = 0; m_key[k] = 0;
            for (int i = 0; i < 255; i++) m_buf[k][i] = 0;
        end
    endfunction

    function automatic void model_lookup(int k);
        byte unsigned v[$];
        case (m_key[k])
            "REV ": v = '{8'h01, 8'h13, 8'h0F, 8'h00, 8'h00, 8'h03};
            "OSK0": for (int i = 0; i < 32; i++) v.push_back(sec_byte(k, i));
            "OSK1": for (int i = 32; i < 64; i++) v.push_back(sec_byte(k, i));
            "NATJ", "MSSP": v = '{8'h00};
            "MSSD": v = '{8'h03};
            default: ;
        endcase
        foreach (v[i]) m_buf[k][i] = v[i];
    endfunction

    function automatic logic [7:0] model_step(int k, bit wr, bit rd,
                                              logic [15:0] a, logic [7:0] d);
        logic [7:0] r = 0;
        bit hit = (a[15:5] == 11'h018);
        if (wr && hit && a[4:0] == 5'd4) begin
            m_cmd[k] = d; m_wpos[k] = 0; m_rpos[k] = 0;
            if (d == 8'h10) m_st[k] = 8'h0C;
        end else if (wr && hit && a[4:0] == 5'd0 && m_cmd[k] == 8'h10) begin
            if (m_wpos[k] < 4) begin
                m_key[k][8*(3-m_wpos[k]) +: 8] = d;
                m_st[k] = 8'h04; m_wpos[k]++;
            end else if (m_wpos[k] == 4) begin
                m_len[k] = d; m_st[k] = 8'h05; m_rpos[k] = 0; m_wpos[k] = 5;
                model_lookup(k);
            end
        end else if (rd && !wr && hit && a[4:0] == 5'd0) begin
            if (m_cmd[k] == 8'h10 && m_rpos[k] < int'(m_len[k])) begin
                r = m_buf[k][m_rpos[k]];
                m_rpos[k]++;
                m_st[k] = (m_rpos[k] == int'(m_len[k])) ? 8'h00 : 8'h05;
            end
        end else if (rd && !wr && hit && a[4:0] == 5'd4) begin
            r = m_st[k];
        end
        return r;
    endfunction

    task automatic acc(bit wr, bit rd, logic [15:0] a, logic [7:0] d, string tag);
        logic [7:0] e0, e1;
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
        #(CLK_PERIOD/4);
        e0 = model_step(0, wr, rd, a, d);
        e1 = model_step(1, wr, rd, a, d);
        checks++;
        if (rdata0 !== e0 || rdata1 !== e1) begin
            bad++;
            $display("FAIL %s addr=%h wr=%0d rd=%0d: actual u0=%h u1=%h expected u0=%h u1=%h",
                     tag, a, wr, rd, rdata0, rdata1, e0, e1);
        end
    endtask

    task automatic wcmd(logic [7:0] c, string tag);  acc(1, 0, 16'h0304, c, tag); endtask
    task automatic wdat(logic [7:0] v, string tag);  acc(1, 0, 16'h0300, v, tag); endtask
    task automatic rdat(string tag);                 acc(0, 1, 16'h0300, 0, tag); endtask
    task automatic rstat(string tag);                acc(0, 1, 16'h0304, 0, tag); endtask
    task automatic idle(string tag);                 acc(0, 0, 16'h0000, 0, tag); endtask

    task automatic request(logic [31:0] key, logic [7:0] len, string tag);
        wcmd(8'h10, "R2"); rstat("R2");
        for (int i = 0; i < 4; i++) begin
            wdat(key[8*(3-i) +: 8], "R3"); rstat("R3");
        end
        wdat(len, tag); rstat("R4");
    endtask

    task automatic stream(int n, string tag);
        for (int i = 0; i < n; i++) begin
            rdat(tag); rstat("R5");
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        idle("R12"); rstat("R12"); rdat("R12");

        request("REV ", 8'd6, "R4"); stream(6, "R8"); rdat("R6"); rstat("R6");
        request("NATJ", 8'd1, "R4"); stream(1, "R8");
        request("MSSP", 8'd1, "R4"); stream(1, "R8");
        request("MSSD", 8'd1, "R4"); stream(1, "R8");
        request("OSK0", 8'd32, "R9"); stream(32, "R9");
        request("OSK1", 8'd32, "R9"); stream(32, "R9");
        request("ZZZZ", 8'd8, "R7"); stream(8, "R7"); rdat("R6");
        request("REV ", 8'd12, "R4"); stream(12, "R4");
        // extra writes after the length byte must not disturb anything
        request("MSSD", 8'd3, "R11");
        wdat(8'h41, "R11"); wdat(8'h42, "R11"); rstat("R11");
        stream(3, "R11");
        // zero-length request
        request("REV ", 8'd0, "R6"); rdat("R6"); rstat("R6");
        // command rewrite mid-read restarts the position
        request("OSK1", 8'd4, "R5"); stream(2, "R5");
        wcmd(8'h10, "R2"); rdat("R2"); rstat("R2");
        // non-read command: status held, data ignored, reads zero
        request("REV ", 8'd2, "R4"); stream(2, "R5");
        wcmd(8'h11, "R2"); rstat("R2"); wdat(8'h52, "R2"); rdat("R6"); rstat("R2");
        wcmd(8'h13, "R2"); rdat("R6");
        // address decode
        request("REV ", 8'd6, "R1");
        acc(0, 1, 16'h0301, 0, "R1"); acc(1, 0, 16'h0308, 8'h10, "R1");
        acc(0, 1, 16'h0320, 0, "R1"); acc(1, 0, 16'h0320, 8'h11, "R1");
        acc(0, 1, 16'h0700, 0, "R1"); acc(1, 0, 16'h0704, 8'h11, "R1");
        rstat("R10"); rstat("R10"); stream(6, "R1");
        // write strobe has priority over read strobe
        acc(1, 1, 16'h0304, 8'h10, "R2"); rstat("R2");
        idle("R12");

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule